// File: doc/BRIEF.md
# Timer Compare Output Unit

This block is an up-counting timer with one output-compare channel and the logic that turns compare events into a waveform bit and a pin value. Each time the timer clock enable is high, the counter advances. When the counter equals the compare register, a match fires. The match raises a one-cycle flag and changes an internal output-compare state bit according to a two-bit action field. A second mode treats the compare value as a variable TOP, so the counter clears when that match fires.

A processor-side write port loads the counter, the compare value and the control bits. Any counter load suppresses the match that would be found on the next timer tick, even if many idle cycles pass before that tick. This lets software line the counter up with the compare value without raising an event. Some limits follow from this: a load equal to the compare value loses that match, and a load equal to TOP in variable-TOP mode sends the counter on to all ones before it wraps.

A force strobe applies the configured action at once, without waiting for a match. The pin stage chooses between the output-compare bit and the port data bit, and passes the direction bit on as the output enable.

Top module: `tcmp_unit`

## Requirements
- R1: On each cycle with `tick_en` high the counter goes up by one and wraps from all ones to zero. A `cnt_wr_en` cycle loads `cnt_wr_data`, and the load wins over a tick in the same cycle.
- R2: After a counter load, the first later cycle with `tick_en` high finds no match, however many idle cycles come before it. Loading the compare value itself therefore raises no flag and leaves `oc_state` unchanged.
- R3: With `ctl_wgm`=1 (variable TOP) the compare value is TOP. An unblocked match clears the counter to zero on that tick. A blocked TOP match lets the counter continue up to all ones and wrap.
- R4: A tick with counter equal to compare, and not blocked, drives `match_flag` high for the cycle after that edge. Without a tick, `match_flag` is low.
- R5: At a match, `oc_state` follows the control action: 00 no change, 01 toggle, 10 clear to 0, 11 set to 1.
- R6: `force_en` applies the action to `oc_state` at the next edge. It raises no flag and does not change the counter. A force and a match in the same cycle apply the action once.
- R7: Reset clears the counter, the compare value, the control bits (action 00, `ctl_wgm` 0), `match_flag` and `oc_state`.
- R8: `oc_state` keeps its value when `ctl_wgm` changes. It changes only at a match or a force.
- R9: A control write is used from the next edge on. It is not held back to wait for any other update.
- R10: When the action is nonzero, `pin_src_oc`=1 and `pin_out`=`oc_state`. Otherwise `pin_out`=`pin_port`. `pin_oe` equals `pin_dir`, and 0 means high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tick_en | input | 1 | timer clock enable |
| cnt_wr_en | input | 1 | counter load strobe |
| cnt_wr_data | input | 16 | counter load value |
| cmp_wr_en | input | 1 | compare value write strobe |
| cmp_wr_data | input | 16 | compare value |
| ctl_wr_en | input | 1 | control write strobe |
| ctl_com | input | 2 | compare action field |
| ctl_wgm | input | 1 | 0 normal, 1 variable TOP |
| force_en | input | 1 | force-compare strobe |
| pin_port | input | 1 | port data bit |
| pin_dir | input | 1 | direction bit, 1 drives |
| cnt_val | output | 16 | counter value |
| match_flag | output | 1 | compare match seen |
| oc_state | output | 1 | output-compare state |
| pin_src_oc | output | 1 | pin driven by compare state |
| pin_out | output | 1 | pin value |
| pin_oe | output | 1 | pin output enable |

## Verification
A force strobe and a true compare match can fall on the same edge. Both request the same action, so a toggle must happen once and not twice. The bench sets up this collision by asserting `force_en` on the tick where the counter reaches the compare value, with the toggle action selected. It expects exactly one toggle, a raised flag and a cleared counter. A second collision puts a counter load on the same cycle as a tick: the load must win, and the next tick must be blocked.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } cmp_act_e;

  typedef enum logic {
    WG_NORMAL = 1'b0,
    WG_VARTOP = 1'b1
  } wg_mode_e;

  // Next value of the compare state bit for a given action.
  function automatic logic act_apply(input cmp_act_e act, input logic cur);
    logic nxt;
    case (act)
      ACT_TOGGLE: nxt = ~cur;
      ACT_CLEAR:  nxt = 1'b0;
      ACT_SET:    nxt = 1'b1;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/tcmp_rst_sync.sv
module tcmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tcmp_counter.sv
module tcmp_counter
  import tcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  wg_mode_e         mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             blk_q, blk_d;
  logic             eq;

  // match detection and blocking window
  always_comb begin
    eq  = (cnt_q == cmp_q);
    hit = tick_en && !cnt_wr_en && !blk_q && eq;
    if (cnt_wr_en)    blk_d = 1'b1;
    else if (tick_en) blk_d = 1'b0;
    else              blk_d = blk_q;
  end

  // counter next state
  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr_en) begin
      cnt_d = cnt_wr_data;
    end else if (tick_en) begin
      if (mode == WG_VARTOP && hit) cnt_d = CNT_ZERO;
      else                          cnt_d = cnt_q + CNT_ONE;
    end
    cmp_d = cmp_wr_en ? cmp_wr_data : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_ZERO;
      cmp_q  <= CNT_ZERO;
      blk_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      blk_q  <= blk_d;
      flag_q <= hit;
    end
  end
endmodule

// File: rtl/tcmp_wavegen.sv
module tcmp_wavegen
  import tcmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctl_wr_en,
  input  logic [1:0] ctl_com,
  input  logic     ctl_wgm,
  input  logic     hit,
  input  logic     force_en,
  output cmp_act_e act_q,
  output wg_mode_e mode_q,
  output logic     oc_q
);
  cmp_act_e act_d;
  wg_mode_e mode_d;
  logic     oc_d;
  logic     fire;

  always_comb begin
    act_d  = act_q;
    mode_d = mode_q;
    if (ctl_wr_en) begin
      act_d  = cmp_act_e'(ctl_com);
      mode_d = wg_mode_e'(ctl_wgm);
    end
    // a match and a force together still act once
    fire = hit || force_en;
    oc_d = fire ? act_apply(act_q, oc_q) : oc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= ACT_NONE;
      mode_q <= WG_NORMAL;
      oc_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      mode_q <= mode_d;
      oc_q   <= oc_d;
    end
  end
endmodule

// File: rtl/tcmp_pinmux.sv
module tcmp_pinmux
  import tcmp_pkg::*;
(
  input  cmp_act_e act,
  input  logic     oc,
  input  logic     port_bit,
  input  logic     dir_bit,
  output logic     src_oc,
  output logic     pin_val,
  output logic     pin_en
);
  always_comb begin
    src_oc  = (act != ACT_NONE);
    pin_val = src_oc ? oc : port_bit;
    pin_en  = dir_bit;
  end
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
  import tcmp_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             ctl_wr_en,
  input  logic [1:0]       ctl_com,
  input  logic             ctl_wgm,
  input  logic             force_en,
  input  logic             pin_port,
  input  logic             pin_dir,
  output logic [CNT_W-1:0] cnt_val,
  output logic             match_flag,
  output logic             oc_state,
  output logic             pin_src_oc,
  output logic             pin_out,
  output logic             pin_oe
);
  logic     rst_sync_n;
  logic     hit;
  cmp_act_e act_q;
  wg_mode_e mode_q;

  tcmp_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tcmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick_en     (tick_en),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .cmp_wr_en   (cmp_wr_en),
    .cmp_wr_data (cmp_wr_data),
    .mode        (mode_q),
    .cnt_q       (cnt_val),
    .hit         (hit),
    .flag_q      (match_flag)
  );

  tcmp_wavegen u_wave (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctl_wr_en (ctl_wr_en),
    .ctl_com   (ctl_com),
    .ctl_wgm   (ctl_wgm),
    .hit       (hit),
    .force_en  (force_en),
    .act_q     (act_q),
    .mode_q    (mode_q),
    .oc_q      (oc_state)
  );

  tcmp_pinmux u_pin (
    .act      (act_q),
    .oc       (oc_state),
    .port_bit (pin_port),
    .dir_bit  (pin_dir),
    .src_oc   (pin_src_oc),
    .pin_val  (pin_out),
    .pin_en   (pin_oe)
  );
endmodule

// File: rtl/tcmp_checker.sv
module tcmp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic             force_en,
  input logic [CNT_W-1:0] cnt_val,
  input logic             match_flag,
  input logic             oc_state,
  input logic             pin_src_oc,
  input logic             pin_out,
  input logic             pin_port,
  input logic             pin_dir,
  input logic             pin_oe
);
  // a load cycle never reports a match at its edge
  assert_load_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> !match_flag);

  // the load value appears in the counter after the edge
  assert_load_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (cnt_val == $past(cnt_wr_data)));

  // no tick, no match
  assert_match_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !match_flag);

  // state bit moves only on a tick (match) or a force
  assert_oc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !force_en) |=> $stable(oc_state));

  // force alone keeps the counter
  assert_force_keeps_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_en && !tick_en && !cnt_wr_en) |=> $stable(cnt_val));

  // pin follows compare state when selected, port otherwise
  assert_pin_mux_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out == (pin_src_oc ? oc_state : pin_port));

  assert_pin_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == pin_dir);
endmodule

bind tcmp_unit tcmp_checker #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick_en     (tick_en),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .force_en    (force_en),
  .cnt_val     (cnt_val),
  .match_flag  (match_flag),
  .oc_state    (oc_state),
  .pin_src_oc  (pin_src_oc),
  .pin_out     (pin_out),
  .pin_port    (pin_port),
  .pin_dir     (pin_dir),
  .pin_oe      (pin_oe)
);

// File: tb/tcmp_unit_tb_top.sv
module tcmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 31;

  typedef struct packed {
    logic        cw;
    logic [15:0] cd;
    logic        mw;
    logic [15:0] md;
    logic        kw;
    logic [1:0]  com;
    logic        wgm;
    logic        tk;
    logic        fc;
    logic [15:0] ecnt;
    logic        ef;
    logic        eoc;
    logic [3:0]  rq;
  } vec_t;

  // cw cd mw md kw com wgm tk fc | cnt flag oc | req
  localparam vec_t VEC [NV] = '{
    '{1'b0,16'h0,1'b1,16'h3,1'b1,2'b01,1'b0,1'b0,1'b0, 16'h0,1'b0,1'b0,4'd9},  // R9 setup
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h1,1'b0,1'b0,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h2,1'b0,1'b0,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h3,1'b0,1'b0,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h4,1'b1,1'b1,4'd5},  // R5 toggle
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b0, 16'h4,1'b0,1'b1,4'd4},  // R4
    '{1'b1,16'h3,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b0, 16'h3,1'b0,1'b1,4'd1},  // R1 load
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h4,1'b0,1'b1,4'd2},  // R2 blocked
    '{1'b1,16'h3,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b0, 16'h3,1'b0,1'b1,4'd2},  // R2
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b0, 16'h3,1'b0,1'b1,4'd2},  // R2 idle
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h4,1'b0,1'b1,4'd2},  // R2 still blocked
    '{1'b1,16'h2,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b0, 16'h2,1'b0,1'b1,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h3,1'b0,1'b1,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h4,1'b1,1'b0,4'd5},  // R5 toggle
    '{1'b0,16'h0,1'b0,16'h0,1'b1,2'b11,1'b0,1'b0,1'b0, 16'h4,1'b0,1'b0,4'd9},  // R9
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b1, 16'h4,1'b0,1'b1,4'd6},  // R6 force set
    '{1'b0,16'h0,1'b0,16'h0,1'b1,2'b10,1'b1,1'b0,1'b0, 16'h4,1'b0,1'b1,4'd8},  // R8
    '{1'b1,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b0, 16'h0,1'b0,1'b1,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h1,1'b0,1'b1,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h2,1'b0,1'b1,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h3,1'b0,1'b1,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h0,1'b1,1'b0,4'd3},  // R3 TOP clear, R5 clear
    '{1'b1,16'h3,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b0, 16'h3,1'b0,1'b0,4'd2},  // R2
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h4,1'b0,1'b0,4'd3},  // R3 passes TOP
    '{1'b1,16'hFFFF,1'b0,16'h0,1'b0,2'b00,1'b0,1'b0,1'b0, 16'hFFFF,1'b0,1'b0,4'd1}, // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h0,1'b0,1'b0,4'd3},  // R3 wrap
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h1,1'b0,1'b0,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b1,2'b01,1'b1,1'b0,1'b0, 16'h1,1'b0,1'b0,4'd9},  // R9
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h2,1'b0,1'b0,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b0, 16'h3,1'b0,1'b0,4'd1},  // R1
    '{1'b0,16'h0,1'b0,16'h0,1'b0,2'b00,1'b0,1'b1,1'b1, 16'h0,1'b1,1'b1,4'd6}   // R6 force+match once
  };

  logic        clk;
  logic        rst_n;
  logic        tick_en, cnt_wr_en, cmp_wr_en, ctl_wr_en, ctl_wgm, force_en;
  logic [15:0] cnt_wr_data, cmp_wr_data, cnt_val;
  logic [1:0]  ctl_com;
  logic        pin_port, pin_dir;
  logic        match_flag, oc_state, pin_src_oc, pin_out, pin_oe;
  int          checks;
  int          errors;
  bit          done;

  tcmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .ctl_wr_en(ctl_wr_en), .ctl_com(ctl_com), .ctl_wgm(ctl_wgm),
    .force_en(force_en), .pin_port(pin_port), .pin_dir(pin_dir),
    .cnt_val(cnt_val), .match_flag(match_flag), .oc_state(oc_state),
    .pin_src_oc(pin_src_oc), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tick_en = 0; cnt_wr_en = 0; cnt_wr_data = '0; cmp_wr_en = 0;
    cmp_wr_data = '0; ctl_wr_en = 0; ctl_com = '0; ctl_wgm = 0; force_en = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    idle_inputs();
    pin_port = 0; pin_dir = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    // R7 reset state
    check("R7", "cnt", cnt_val, 16'h0);
    check("R7", "flag", {15'b0, match_flag}, 16'h0);
    check("R7", "oc", {15'b0, oc_state}, 16'h0);
    check("R7", "src", {15'b0, pin_src_oc}, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cnt_wr_en = VEC[i].cw; cnt_wr_data = VEC[i].cd;
      cmp_wr_en = VEC[i].mw; cmp_wr_data = VEC[i].md;
      ctl_wr_en = VEC[i].kw; ctl_com = VEC[i].com; ctl_wgm = VEC[i].wgm;
      tick_en = VEC[i].tk; force_en = VEC[i].fc;
      step();
      idle_inputs();
      check($sformatf("R%0d row%0d", VEC[i].rq, i), "cnt", cnt_val, VEC[i].ecnt);
      check($sformatf("R%0d row%0d", VEC[i].rq, i), "flag", {15'b0, match_flag}, {15'b0, VEC[i].ef});
      check($sformatf("R%0d row%0d", VEC[i].rq, i), "oc", {15'b0, oc_state}, {15'b0, VEC[i].eoc});
    end

    // R10 pin select: action is toggle, oc=1
    pin_dir = 0; pin_port = 0; #1;
    check("R10", "oe off", {15'b0, pin_oe}, 16'h0);
    check("R10", "src oc", {15'b0, pin_src_oc}, 16'h1);
    pin_dir = 1; #1;
    check("R10", "oe on", {15'b0, pin_oe}, 16'h1);
    check("R10", "pin=oc", {15'b0, pin_out}, 16'h1);
    // R9 action 00 acts at next edge
    ctl_wr_en = 1; ctl_com = 2'b00; ctl_wgm = 1;
    step();
    idle_inputs();
    check("R9", "src after write", {15'b0, pin_src_oc}, 16'h0);
    check("R10", "pin=port", {15'b0, pin_out}, 16'h0);
    pin_port = 1; #1;
    check("R10", "pin=port 1", {15'b0, pin_out}, 16'h1);
    // R5 action 00 leaves oc alone at a match (cnt 0 -> match at 3)
    for (int k = 0; k < 4; k++) begin
      tick_en = 1; step();
    end
    tick_en = 0;
    check("R5", "flag none", {15'b0, match_flag}, 16'h1);
    check("R5", "oc none", {15'b0, oc_state}, 16'h1);
    check("R3", "cnt cleared", cnt_val, 16'h0);

    // R7 asynchronous reset mid-run
    rst_n = 0; #1;
    check("R7", "oc after reset", {15'b0, oc_state}, 16'h0);
    check("R7", "flag after reset", {15'b0, match_flag}, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R7", "cnt after reset", cnt_val, 16'h0);
    check("R7", "src after reset", {15'b0, pin_src_oc}, 16'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule